// File: doc/BRIEF.md
# Bridge Master-Abort Error Handler

This block sits beside the forwarding engine of a two-sided bus bridge and decides what happens when a transaction the bridge launched ends in master abort. Each bus interface reports an abort event with a two-bit kind tag. From these events the block does four things. It tells the posted-write queue to drop the data of a write that can no longer be delivered. It records the abort in a sticky status bit belonging to the side that saw it. It pulses an active-low system-error line when the configuration bits allow it. It tells the configuration path to end a converted special cycle after its first data phase.

An abort on a special cycle that was converted from a type 1 configuration access is the normal way such a cycle ends. That kind is therefore never treated as an error. The status bits are cleared by write-1-to-clear strobes from the register interface. When a set and a clear reach the same bit in the same cycle, the set takes precedence. Bus sequencing, the data queues and address decoding are outside this block.

Kind encoding: 2'b00 posted write, 2'b01 delayed transaction, 2'b10 special cycle converted from a type 1 configuration access, 2'b11 handled exactly as a delayed transaction.

Top module: `bridge_mabort_ctl`

## Requirements
- R1: A valid posted-write abort (kind 2'b00) on one side produces a one-clock high pulse on that side's flush output in the cycle after the event, and on no other flush output.
- R2: A valid abort of kind 2'b00, 2'b01 or 2'b11 on the primary side sets the primary received-abort status bit, which is visible one cycle after the event.
- R3: A valid abort of kind 2'b00, 2'b01 or 2'b11 on the secondary side sets the secondary received-abort status bit, which is visible one cycle after the event.
- R4: The error output goes low for exactly one clock, one cycle after a cycle containing at least one posted-write abort, and only when abort-mode = 1, error-enable = 1 and posted-abort-error-disable = 0. Aborts of other kinds never drive it low.
- R5: A special-cycle abort (kind 2'b10) sets no status bit, requests no flush and does not drive the error output low.
- R6: A special-cycle abort on either side produces a one-clock high pulse on the disconnect output one cycle later.
- R7: Status bits are sticky. A bit stays set until its clear strobe is high, and the bit reads 0 from the following cycle.
- R8: When a set event and the clear strobe reach the same status bit in the same cycle, the bit is 1 afterwards.
- R9: Aborts on both sides in the same cycle are handled independently, and each one updates only its own status bit and flush output.
- R10: During and after reset, both status bits, both flush outputs and the disconnect output are 0 and the error output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_abort_vld | input | 1 | Primary side saw a master abort this cycle |
| pri_abort_kind | input | 2 | Kind of the primary abort |
| sec_abort_vld | input | 1 | Secondary side saw a master abort this cycle |
| sec_abort_kind | input | 2 | Kind of the secondary abort |
| cfg_abort_mode | input | 1 | Abort-mode control bit |
| cfg_err_en | input | 1 | System-error enable bit |
| cfg_pw_err_dis | input | 1 | Disables error reporting for posted-write aborts |
| pri_sta_clr | input | 1 | Write-1-to-clear strobe for the primary status bit |
| sec_sta_clr | input | 1 | Write-1-to-clear strobe for the secondary status bit |
| pri_rcv_abort | output | 1 | Sticky primary received-abort status |
| sec_rcv_abort | output | 1 | Sticky secondary received-abort status |
| pri_pw_flush | output | 1 | Drop-data pulse toward the queue feeding the primary side |
| sec_pw_flush | output | 1 | Drop-data pulse toward the queue feeding the secondary side |
| spc_disc | output | 1 | End the converted configuration access after its first data phase |
| sys_err_n | output | 1 | Active-low system-error pulse |

## Verification
The hardest situations to reach from the ports are coincidences. One is a set and a clear striking the same status bit in the same cycle. Another is both sides aborting together with mixed kinds while exactly the right combination of the three gating bits is present. Purely uniform stimulus seldom lines these up with a bit that is already in a known state. The bench therefore drives a seeded random phase in which clears, both-side events and gating-bit changes are biased toward frequent overlap, and it adds directed sequences that force each collision explicitly and walk all eight gating combinations.

// File: rtl/mab_pkg.sv
package mab_pkg;
   localparam int KIND_W = 2;

   typedef enum logic [KIND_W-1:0] {
      KIND_POSTED  = 2'b00,
      KIND_DELAYED = 2'b01,
      KIND_SPCYCLE = 2'b10,
      KIND_SPARE   = 2'b11
   } abort_kind_e;

   localparam int SIDES    = 2;
   localparam int SIDE_PRI = 0;
   localparam int SIDE_SEC = 1;
endpackage

// File: rtl/mab_classify.sv
module mab_classify
   import mab_pkg::*;
(
   input  logic              vld,
   input  logic [KIND_W-1:0] kind,
   output logic              pw_hit,
   output logic              sta_set,
   output logic              spc_hit
);
   abort_kind_e k;

   always_comb begin
      k       = abort_kind_e'(kind);
      pw_hit  = 1'b0;
      sta_set = 1'b0;
      spc_hit = 1'b0;
      if (vld) begin
         unique case (k)
            KIND_POSTED: begin
               pw_hit  = 1'b1;
               sta_set = 1'b1;
            end
            KIND_SPCYCLE: spc_hit = 1'b1;
            default:      sta_set = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/mab_sticky.sv
module mab_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R7: a set bit holds unless cleared
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q && !clr |=> q);
   // R7: a clear without a set empties the bit
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set |=> !q);
   // R8: set beats a simultaneous clear
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set && clr |=> q);
endmodule

// File: rtl/mab_serr_gen.sv
module mab_serr_gen #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pw_any,
   input  logic abort_mode,
   input  logic err_en,
   input  logic pw_err_dis,
   output logic sys_err_n
);
   logic fire;
   assign fire = pw_any & abort_mode & err_en & ~pw_err_dis;

   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("mab_serr_gen: STAGES must be 1..4");
   end

   if (STAGES == 1) begin : g_direct
      logic err_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_q <= 1'b0;
         else        err_q <= fire;
      end
      assign sys_err_n = ~err_q;

      // R4: low only after a qualifying posted-write abort
      p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !sys_err_n |-> $past(pw_any && abort_mode && err_en && !pw_err_dis));
   end else begin : g_piped
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[STAGES-2:0], fire};
      end
      assign sys_err_n = ~pipe_q[STAGES-1];
   end
endmodule

// File: rtl/bridge_mabort_ctl.sv
module bridge_mabort_ctl
   import mab_pkg::*;
#(
   parameter int SERR_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pri_abort_vld,
   input  logic [KIND_W-1:0] pri_abort_kind,
   input  logic              sec_abort_vld,
   input  logic [KIND_W-1:0] sec_abort_kind,
   input  logic              cfg_abort_mode,
   input  logic              cfg_err_en,
   input  logic              cfg_pw_err_dis,
   input  logic              pri_sta_clr,
   input  logic              sec_sta_clr,
   output logic              pri_rcv_abort,
   output logic              sec_rcv_abort,
   output logic              pri_pw_flush,
   output logic              sec_pw_flush,
   output logic              spc_disc,
   output logic              sys_err_n
);
   logic              ev_vld  [SIDES];
   logic [KIND_W-1:0] ev_kind [SIDES];
   logic              ev_clr  [SIDES];
   logic [SIDES-1:0]  pw_hit, sta_set, spc_hit, sta_q, flush_q;
   logic              disc_q;

   assign ev_vld[SIDE_PRI]  = pri_abort_vld;
   assign ev_vld[SIDE_SEC]  = sec_abort_vld;
   assign ev_kind[SIDE_PRI] = pri_abort_kind;
   assign ev_kind[SIDE_SEC] = sec_abort_kind;
   assign ev_clr[SIDE_PRI]  = pri_sta_clr;
   assign ev_clr[SIDE_SEC]  = sec_sta_clr;

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      mab_classify u_cls (
         .vld    (ev_vld[s]),
         .kind   (ev_kind[s]),
         .pw_hit (pw_hit[s]),
         .sta_set(sta_set[s]),
         .spc_hit(spc_hit[s])
      );

      mab_sticky u_sta (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (sta_set[s]),
         .clr  (ev_clr[s]),
         .q    (sta_q[s])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flush_q[s] <= 1'b0;
         else        flush_q[s] <= pw_hit[s];
      end

      // R1: posted-write abort leads to a flush on this side
      p_flush_r1: assert property (@(posedge clk) disable iff (!rst_n)
         ev_vld[s] && ev_kind[s] == KIND_POSTED |=> flush_q[s]);
      // R5: special-cycle abort leaves a clear status bit clear
      p_spc_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ev_vld[s] && ev_kind[s] == KIND_SPCYCLE && !sta_q[s] |=> !sta_q[s]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) disc_q <= 1'b0;
      else        disc_q <= |spc_hit;
   end

   mab_serr_gen #(.STAGES(SERR_STAGES)) u_serr (
      .clk       (clk),
      .rst_n     (rst_n),
      .pw_any    (|pw_hit),
      .abort_mode(cfg_abort_mode),
      .err_en    (cfg_err_en),
      .pw_err_dis(cfg_pw_err_dis),
      .sys_err_n (sys_err_n)
   );

   assign pri_rcv_abort = sta_q[SIDE_PRI];
   assign sec_rcv_abort = sta_q[SIDE_SEC];
   assign pri_pw_flush  = flush_q[SIDE_PRI];
   assign sec_pw_flush  = flush_q[SIDE_SEC];
   assign spc_disc      = disc_q;

   // R6: disconnect pulse only follows a special-cycle abort
   p_disc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      spc_disc |-> $past((pri_abort_vld && pri_abort_kind == KIND_SPCYCLE) ||
                         (sec_abort_vld && sec_abort_kind == KIND_SPCYCLE)));
   // R9: a primary abort sets the primary bit regardless of the secondary side
   p_pri_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pri_abort_vld && pri_abort_kind != KIND_SPCYCLE |=> pri_rcv_abort);
   // R9: a secondary abort sets the secondary bit regardless of the primary side
   p_sec_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sec_abort_vld && sec_abort_kind != KIND_SPCYCLE |=> sec_rcv_abort);
   // R10: outputs at rest while reset is held
   always_comb begin
      if (!rst_n) begin
         a_reset_r10: assert (!pri_rcv_abort && !sec_rcv_abort && sys_err_n && !spc_disc);
      end
   end
endmodule

// File: tb/bridge_mabort_ctl_bench.sv
module bridge_mabort_ctl_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic pv = 0, sv = 0, mode = 0, en = 0, dis = 0, pc = 0, sc = 0;
   logic [1:0] pk = 0, sk = 0;
   logic pri_rcv_abort, sec_rcv_abort, pri_pw_flush, sec_pw_flush, spc_disc, sys_err_n;
   int checks = 0, errors = 0;
   logic e_pri = 0, e_sec = 0, e_fp = 0, e_fs = 0, e_disc = 0, e_err_n = 1;

   always #10 clk = ~clk;

   bridge_mabort_ctl u_bridge_mabort_ctl (
      .clk(clk), .rst_n(rst_n),
      .pri_abort_vld(pv), .pri_abort_kind(pk),
      .sec_abort_vld(sv), .sec_abort_kind(sk),
      .cfg_abort_mode(mode), .cfg_err_en(en), .cfg_pw_err_dis(dis),
      .pri_sta_clr(pc), .sec_sta_clr(sc),
      .pri_rcv_abort(pri_rcv_abort), .sec_rcv_abort(sec_rcv_abort),
      .pri_pw_flush(pri_pw_flush), .sec_pw_flush(sec_pw_flush),
      .spc_disc(spc_disc), .sys_err_n(sys_err_n));

   function automatic logic sets(logic v, logic [1:0] k);
      return v && k != 2'b10;
   endfunction
   function automatic logic is_pw(logic v, logic [1:0] k);
      return v && k == 2'b00;
   endfunction
   function automatic logic is_spc(logic v, logic [1:0] k);
      return v && k == 2'b10;
   endfunction

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " R1 pri flush"}, pri_pw_flush, e_fp);
      chk({tag, " R1 sec flush"}, sec_pw_flush, e_fs);
      chk({tag, " R2 pri status"}, pri_rcv_abort, e_pri);
      chk({tag, " R3 sec status"}, sec_rcv_abort, e_sec);
      chk({tag, " R4 error"}, sys_err_n, e_err_n);
      chk({tag, " R6 disconnect"}, spc_disc, e_disc);
   endtask

   // called at a falling edge; applies inputs, predicts, checks at next falling edge
   task automatic step(string tag, logic a_pv, logic [1:0] a_pk, logic a_sv,
                       logic [1:0] a_sk, logic a_pc, logic a_sc);
      pv = a_pv; pk = a_pk; sv = a_sv; sk = a_sk; pc = a_pc; sc = a_sc;
      e_pri   = sets(pv, pk) ? 1'b1 : (pc ? 1'b0 : e_pri);
      e_sec   = sets(sv, sk) ? 1'b1 : (sc ? 1'b0 : e_sec);
      e_fp    = is_pw(pv, pk);
      e_fs    = is_pw(sv, sk);
      e_disc  = is_spc(pv, pk) || is_spc(sv, sk);
      e_err_n = !((is_pw(pv, pk) || is_pw(sv, sk)) && mode && en && !dis);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check_all("R10 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R10 after reset");

      mode = 1; en = 1; dis = 0;
      step("R1 R2 R4 pri posted", 1, 2'b00, 0, 2'b00, 0, 0);
      step("R7 hold", 0, 2'b00, 0, 2'b00, 0, 0);
      step("R7 clear", 0, 2'b00, 0, 2'b00, 1, 0);
      step("R3 sec delayed", 0, 2'b00, 1, 2'b01, 0, 0);
      step("R3 sec spare kind", 0, 2'b00, 1, 2'b11, 0, 1);
      step("R7 clear sec", 0, 2'b00, 0, 2'b00, 0, 1);
      step("R5 R6 pri special", 1, 2'b10, 0, 2'b00, 0, 0);
      step("R5 R6 sec special", 0, 2'b00, 1, 2'b10, 0, 0);
      step("R8 pri set+clear", 1, 2'b01, 0, 2'b00, 1, 0);
      step("R8 sec set+clear", 0, 2'b00, 1, 2'b00, 0, 1);
      step("R9 both posted", 1, 2'b00, 1, 2'b00, 1, 1);
      step("R9 mixed", 1, 2'b10, 1, 2'b00, 1, 0);
      step("R9 mixed clear", 0, 2'b00, 0, 2'b00, 1, 1);
      // R4: every gating combination with a posted write
      for (int g = 0; g < 8; g++) begin
         mode = g[0]; en = g[1]; dis = g[2];
         step("R4 gate", 1, 2'b00, 0, 2'b00, 0, 0);
         step("R4 delayed no error", 1, 2'b01, 1, 2'b11, 0, 0);
      end
      // random phase with biased coincidences
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 15) == 0) begin
            mode = $urandom_range(0, 3) != 0;
            en   = $urandom_range(0, 3) != 0;
            dis  = $urandom_range(0, 3) == 0;
         end
         step("rand", $urandom_range(0, 1), 2'($urandom_range(0, 3)),
              $urandom_range(0, 1), 2'($urandom_range(0, 3)),
              $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
      end
      step("drain", 0, 2'b00, 0, 2'b00, 0, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule